// File: doc/BRIEF.md
# SPI Passthrough Read Return Path with Per-Command Pipelining

This block sits between an upstream SPI host and a downstream SPI flash and forwards every transaction in both directions. It shifts in the opcode of each command and looks it up in a small programmable command table. The matching entry gives four things: the number of address bytes, the flash's own dummy-cycle count, the read-data lane width, and whether read data returns to the host directly or through a chain of SCK-clocked register stages.

When a command uses the registered return path, the host must be told to wait longer. The block counts a host-side dummy window equal to the flash's native count plus the pipeline depth. The flash still sees its native timing, and its data is delayed by exactly the pipeline depth. The host then samples registered data, so the round-trip combinational path is cut in two. On the trailing SCK cycles the flash keeps returning data that the host never requested. That data stays in the pipeline and is discarded when chip select rises.

Top module: `spi_pt_readpipe`

## Requirements
- R1: During the 8 opcode cycles after chip select falls, the opcode is taken MSB first from host lane 0. Host lanes are forwarded to the flash, and the flash output enable is 4'b0001 while the host drives it.
- R2: For a command with a valid table entry, the address phase lasts 8 cycles per address byte (0 to 3 bytes). In it the flash output enable stays 4'b0001 and the host output enable stays 4'b0000.
- R3: While the opcode is being received, and for every command whose entry has the pipeline flag clear, the host data equals the live flash data in the same cycle.
- R4: For a command whose entry has the pipeline flag set, data-phase host data equals the flash data from DEPTH cycles earlier.
- R5: The host dummy window lasts the native count, plus DEPTH when the command is pipelined. In it both output enables are 4'b0000, and the data phase starts right after.
- R6: Host dummy counts above 8 are supported (native 8 with DEPTH 1 gives 9).
- R7: Opcode 8'h03 always uses the direct path, even when its table entry sets the pipeline flag.
- R8: In the data phase the host output enable follows the entry's lane code: 0 gives 4'b0010, 1 gives 4'b0011, 2 gives 4'b1111, and 3 gives 4'b0010.
- R9: While chip select is high, or during reset, both output enables are 4'b0000. A transaction cut short by chip select rising leaves no trace on the next one.
- R10: An opcode with no valid entry is forwarded unchanged on the direct path. From cycle 8 on, the host output enable is 4'b0010 and the flash output enable is 4'b0001.
- R11: The table write port stores an entry at the given index on an SCK edge, and reset invalidates all entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset, clears the command table |
| host_sck | input | 1 | Serial clock from the host |
| host_csb | input | 1 | Active-low chip select from the host |
| host_sd_i | input | 4 | Data lanes driven by the host |
| host_sd_o | output | 4 | Data lanes returned to the host |
| host_sd_oe | output | 4 | Per-lane output enable toward the host |
| flash_sck | output | 1 | Serial clock forwarded to the flash |
| flash_csb | output | 1 | Chip select forwarded to the flash |
| flash_sd_o | output | 4 | Data lanes forwarded to the flash |
| flash_sd_oe | output | 4 | Per-lane output enable toward the flash |
| flash_sd_i | input | 4 | Data lanes returned by the flash |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | IDX_W | Table entry index |
| tbl_valid | input | 1 | Entry valid flag |
| tbl_opcode | input | 8 | Opcode the entry matches |
| tbl_piped | input | 1 | Return read data through the register stages |
| tbl_lanes | input | 2 | Data lane code |
| tbl_addr_bytes | input | 2 | Address length in bytes |
| tbl_dummy | input | 4 | Native flash dummy-cycle count |

## Verification
The flash model returns a value that is a known function of the cycle index. This lets the bench tell a delayed sample from a live one at every data cycle, so the direct and registered paths cannot be confused. A sweep over pipeline flag, lane code, address length and native dummy count (0, 1, 7, 13) checks where every phase boundary falls and which path is selected. The directed cases each separate one condition: a read opcode with the pipeline flag set that must stay direct, a pipelined count that goes past 8, an unknown opcode, an unprogrammed table, and a transaction aborted mid-address.

// File: rtl/spt_pkg.sv
package spt_pkg;

  typedef enum logic [2:0] {
    PH_CMD    = 3'd0,
    PH_ADDR   = 3'd1,
    PH_DUMMY  = 3'd2,
    PH_DATA   = 3'd3,
    PH_BYPASS = 3'd4
  } phase_e;

  typedef struct packed {
    logic       valid;
    logic [7:0] opcode;
    logic       piped;
    logic [1:0] lanes;
    logic [1:0] addr_bytes;
    logic [3:0] dummy;
  } cmd_ent_t;

  localparam logic [7:0] OP_PLAIN_READ = 8'h03;
  localparam int OP_BITS   = 8;
  localparam int ADDR_MAX  = 24;
  localparam int DEPTH_MAX = 2;
  localparam int HD_MAX    = 15 + DEPTH_MAX;
  localparam int CNT_W     = $clog2(((ADDR_MAX > HD_MAX) ? ADDR_MAX : HD_MAX) + 1);

  function automatic logic [3:0] lane_oe(input logic [1:0] code);
    case (code)
      2'd1:    return 4'b0011;
      2'd2:    return 4'b1111;
      default: return 4'b0010;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] addr_cycles(input logic [1:0] nbytes);
    return CNT_W'({nbytes, 3'b000});
  endfunction

  function automatic logic [CNT_W-1:0] host_dummy(input logic [3:0] native,
                                                  input logic piped, input int depth);
    return CNT_W'(native) + (piped ? CNT_W'(depth) : CNT_W'(0));
  endfunction

endpackage

// File: rtl/spt_cmd_table.sv
module spt_cmd_table
  import spt_pkg::*;
#(
  parameter int N_ENT = 4,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  cmd_ent_t         wdata,
  input  logic [7:0]       look_op,
  output logic             hit,
  output logic             hit_piped,
  output logic [1:0]       hit_lanes,
  output logic [1:0]       hit_addr_bytes,
  output logic [3:0]       hit_dummy
);

  cmd_ent_t tbl [N_ENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) tbl[i] <= '0;
    end else if (we) begin
      tbl[widx] <= wdata;
    end
  end

  // Lowest matching index wins.
  always_comb begin
    hit            = 1'b0;
    hit_piped      = 1'b0;
    hit_lanes      = 2'd0;
    hit_addr_bytes = 2'd0;
    hit_dummy      = 4'd0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (tbl[i].valid && (tbl[i].opcode == look_op)) begin
        hit            = 1'b1;
        hit_piped      = tbl[i].piped;
        hit_lanes      = tbl[i].lanes;
        hit_addr_bytes = tbl[i].addr_bytes;
        hit_dummy      = tbl[i].dummy;
      end
    end
  end

endmodule

// File: rtl/spt_seq.sv
module spt_seq
  import spt_pkg::*;
#(
  parameter int DEPTH = 1
) (
  input  logic       sck,
  input  logic       clr,
  input  logic       sd0,
  output logic [7:0] op_next,
  input  logic       lk_hit,
  input  logic       lk_piped,
  input  logic [1:0] lk_lanes,
  input  logic [1:0] lk_addr_bytes,
  input  logic [3:0] lk_dummy,
  output phase_e     phase,
  output logic       sel_pipe,
  output logic       dec_evt,
  output logic [3:0] host_oe,
  output logic [3:0] flash_oe
);

  logic [OP_BITS-2:0] op_sr;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   acyc_q, hd_q;
  logic [1:0]         lanes_q;

  logic               dec_piped;
  logic [CNT_W-1:0]   dec_acyc, dec_hd;
  logic               addr_last, dummy_last;

  assign op_next    = {op_sr, sd0};
  assign dec_evt    = (phase == PH_CMD) && (cnt == CNT_W'(OP_BITS - 1));
  assign dec_piped  = lk_hit && lk_piped && (op_next != OP_PLAIN_READ);
  assign dec_acyc   = addr_cycles(lk_addr_bytes);
  assign dec_hd     = host_dummy(lk_dummy, dec_piped, DEPTH);
  assign addr_last  = (phase == PH_ADDR)  && (cnt == acyc_q - CNT_W'(1));
  assign dummy_last = (phase == PH_DUMMY) && (cnt == hd_q - CNT_W'(1));

  always_ff @(posedge sck or posedge clr) begin
    if (clr) begin
      phase    <= PH_CMD;
      cnt      <= '0;
      op_sr    <= '0;
      acyc_q   <= '0;
      hd_q     <= '0;
      lanes_q  <= '0;
      sel_pipe <= 1'b0;
    end else begin
      case (phase)
        PH_CMD: begin
          op_sr <= op_next[OP_BITS-2:0];
          if (dec_evt) begin
            cnt      <= '0;
            acyc_q   <= dec_acyc;
            hd_q     <= dec_hd;
            lanes_q  <= lk_lanes;
            sel_pipe <= dec_piped;
            if (!lk_hit)             phase <= PH_BYPASS;
            else if (dec_acyc != '0) phase <= PH_ADDR;
            else if (dec_hd != '0)   phase <= PH_DUMMY;
            else                     phase <= PH_DATA;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        PH_ADDR: begin
          if (addr_last) begin
            cnt   <= '0;
            phase <= (hd_q != '0) ? PH_DUMMY : PH_DATA;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        PH_DUMMY: begin
          if (dummy_last) begin
            cnt   <= '0;
            phase <= PH_DATA;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    host_oe  = 4'b0000;
    flash_oe = 4'b0000;
    case (phase)
      PH_CMD, PH_ADDR: flash_oe = 4'b0001;
      PH_DATA:         host_oe  = lane_oe(lanes_q);
      PH_BYPASS: begin
        host_oe  = 4'b0010;
        flash_oe = 4'b0001;
      end
      default: ;
    endcase
  end

  AST_CMD_DIRECT: assert property (@(posedge sck) disable iff (clr)
    (phase == PH_CMD) |-> !sel_pipe); // R3

  AST_PLAIN_READ_DIRECT: assert property (@(posedge sck) disable iff (clr)
    (dec_evt && (op_next == OP_PLAIN_READ)) |=> !sel_pipe); // R7

  AST_DUMMY_BOUND: assert property (@(posedge sck) disable iff (clr)
    (phase == PH_DUMMY) |-> (cnt < hd_q)); // R6

  AST_DUMMY_QUIET: assert property (@(posedge sck) disable iff (clr)
    (phase == PH_DUMMY) |-> (host_oe == 4'b0000 && flash_oe == 4'b0000)); // R5

endmodule

// File: rtl/spt_ret_pipe.sv
module spt_ret_pipe #(
  parameter int DEPTH = 1
) (
  input  logic       sck,
  input  logic       clr,
  input  logic       sel_pipe,
  input  logic [3:0] live,
  output logic [3:0] dout
);

  logic [3:0] stg [DEPTH];
  logic       primed;

  always_ff @(posedge sck or posedge clr) begin
    if (clr) begin
      stg[0] <= '0;
      primed <= 1'b0;
    end else begin
      stg[0] <= live;
      primed <= 1'b1;
    end
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge sck or posedge clr) begin
      if (clr) stg[g] <= '0;
      else     stg[g] <= stg[g-1];
    end

    AST_STAGE_SHIFT: assert property (@(posedge sck) disable iff (clr)
      stg[g] == $past(stg[g-1])); // R4
  end

  assign dout = sel_pipe ? stg[DEPTH-1] : live;

  AST_FIRST_STAGE: assert property (@(posedge sck) disable iff (clr)
    primed |-> (stg[0] == $past(live))); // R4

endmodule

// File: rtl/spi_pt_readpipe.sv
module spi_pt_readpipe
  import spt_pkg::*;
#(
  parameter int N_ENT = 4,
  parameter int DEPTH = 1,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             rst_n,
  input  logic             host_sck,
  input  logic             host_csb,
  input  logic [3:0]       host_sd_i,
  output logic [3:0]       host_sd_o,
  output logic [3:0]       host_sd_oe,
  output logic             flash_sck,
  output logic             flash_csb,
  output logic [3:0]       flash_sd_o,
  output logic [3:0]       flash_sd_oe,
  input  logic [3:0]       flash_sd_i,
  input  logic             tbl_we,
  input  logic [IDX_W-1:0] tbl_idx,
  input  logic             tbl_valid,
  input  logic [7:0]       tbl_opcode,
  input  logic             tbl_piped,
  input  logic [1:0]       tbl_lanes,
  input  logic [1:0]       tbl_addr_bytes,
  input  logic [3:0]       tbl_dummy
);

  logic       clr;
  cmd_ent_t   wr_ent;
  logic [7:0] op_next;
  logic       lk_hit, lk_piped;
  logic [1:0] lk_lanes, lk_addr_bytes;
  logic [3:0] lk_dummy;
  phase_e     phase;
  logic       sel_pipe, dec_evt;
  logic [3:0] host_oe_raw, flash_oe_raw;

  assign clr    = host_csb | ~rst_n;
  assign wr_ent = '{valid: tbl_valid, opcode: tbl_opcode, piped: tbl_piped,
                    lanes: tbl_lanes, addr_bytes: tbl_addr_bytes, dummy: tbl_dummy};

  spt_cmd_table #(.N_ENT(N_ENT)) u_table (
    .clk(host_sck), .rst_n(rst_n), .we(tbl_we), .widx(tbl_idx), .wdata(wr_ent),
    .look_op(op_next), .hit(lk_hit), .hit_piped(lk_piped), .hit_lanes(lk_lanes),
    .hit_addr_bytes(lk_addr_bytes), .hit_dummy(lk_dummy)
  );

  spt_seq #(.DEPTH(DEPTH)) u_seq (
    .sck(host_sck), .clr(clr), .sd0(host_sd_i[0]), .op_next(op_next),
    .lk_hit(lk_hit), .lk_piped(lk_piped), .lk_lanes(lk_lanes),
    .lk_addr_bytes(lk_addr_bytes), .lk_dummy(lk_dummy), .phase(phase),
    .sel_pipe(sel_pipe), .dec_evt(dec_evt), .host_oe(host_oe_raw), .flash_oe(flash_oe_raw)
  );

  spt_ret_pipe #(.DEPTH(DEPTH)) u_pipe (
    .sck(host_sck), .clr(clr), .sel_pipe(sel_pipe), .live(flash_sd_i), .dout(host_sd_o)
  );

  assign flash_sck   = host_sck;
  assign flash_csb   = host_csb;
  assign flash_sd_o  = host_sd_i;
  assign host_sd_oe  = clr ? 4'b0000 : host_oe_raw;
  assign flash_sd_oe = clr ? 4'b0000 : flash_oe_raw;

  AST_OE_RELEASE: assert property (@(posedge host_sck) disable iff (!rst_n)
    host_csb |-> (host_sd_oe == 4'b0000 && flash_sd_oe == 4'b0000)); // R9

  AST_BYPASS_DIRECT: assert property (@(posedge host_sck) disable iff (clr)
    (dec_evt && !lk_hit) |=> (!sel_pipe && phase == PH_BYPASS)); // R10

  initial begin
    assert (DEPTH >= 1 && DEPTH <= DEPTH_MAX); // R4
  end

endmodule

// File: tb/tb_spi_pt_readpipe.sv
`timescale 1ns/1ps
module tb_spi_pt_readpipe;

  localparam int N_ENT = 4;
  localparam int DEPTH = 1;

  logic       sck = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_csb = 1'b1;
  logic [3:0] host_sd_i = '0;
  logic [3:0] host_sd_o, host_sd_oe, flash_sd_o, flash_sd_oe, flash_sd_i;
  logic       flash_sck, flash_csb;
  logic       tbl_we = 1'b0;
  logic [1:0] tbl_idx = '0;
  logic       tbl_valid = 1'b0;
  logic [7:0] tbl_opcode = '0;
  logic       tbl_piped = 1'b0;
  logic [1:0] tbl_lanes = '0;
  logic [1:0] tbl_addr_bytes = '0;
  logic [3:0] tbl_dummy = '0;

  int n_chk = 0;
  int n_fail = 0;
  int tcyc = 0;

  always #5 sck = ~sck;

  always @(posedge sck) begin
    if (host_csb) tcyc <= 0;
    else          tcyc <= tcyc + 1;
  end

  function automatic logic [3:0] fdat(input int t);
    return 4'(((t * 5) + 3) ^ (t / 4));
  endfunction

  assign flash_sd_i = fdat(tcyc);

  spi_pt_readpipe #(.N_ENT(N_ENT), .DEPTH(DEPTH)) dut (
    .rst_n(rst_n), .host_sck(sck), .host_csb(host_csb), .host_sd_i(host_sd_i),
    .host_sd_o(host_sd_o), .host_sd_oe(host_sd_oe), .flash_sck(flash_sck),
    .flash_csb(flash_csb), .flash_sd_o(flash_sd_o), .flash_sd_oe(flash_sd_oe),
    .flash_sd_i(flash_sd_i), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_valid(tbl_valid),
    .tbl_opcode(tbl_opcode), .tbl_piped(tbl_piped), .tbl_lanes(tbl_lanes),
    .tbl_addr_bytes(tbl_addr_bytes), .tbl_dummy(tbl_dummy)
  );

  task automatic chk(input bit ok, input string req, input logic [3:0] act,
                     input logic [3:0] exp, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_mask(input logic [1:0] code);
    if (code == 2'd2) return 4'hF;
    if (code == 2'd1) return 4'h3;
    return 4'h2;
  endfunction

  task automatic prog(input int idx, input bit v, input logic [7:0] op, input bit p,
                      input logic [1:0] ln, input logic [1:0] ab, input logic [3:0] nd);
    @(negedge sck);
    tbl_we = 1'b1; tbl_idx = 2'(idx); tbl_valid = v; tbl_opcode = op;
    tbl_piped = p; tbl_lanes = ln; tbl_addr_bytes = ab; tbl_dummy = nd;
    @(negedge sck);
    tbl_we = 1'b0;
  endtask

  // Entry fields passed here are those the bench expects to be in effect.
  task automatic run_txn(input logic [7:0] op, input bit v, input bit p,
                         input logic [1:0] ln, input logic [1:0] ab, input logic [3:0] nd,
                         input int ndata, input int abort_at, input string tag);
    int  a_len, hd, d0, total;
    bit  eff;
    logic [3:0] ev;
    a_len = int'(ab) * 8;
    eff   = v && p && (op != 8'h03);
    hd    = int'(nd) + (eff ? DEPTH : 0);
    d0    = 8 + a_len + hd;
    total = v ? d0 + ndata : 8 + ndata;
    @(negedge sck);
    host_csb = 1'b0;
    for (int t = 0; t < total; t++) begin
      if (t == abort_at) break;
      if (t < 8)              host_sd_i = {3'b000, op[7 - t]};
      else if (t < 8 + a_len) host_sd_i = {3'b000, 1'(t % 2)};
      else                    host_sd_i = 4'h0;
      #1;
      if (t < 8) begin
        chk(host_sd_oe == 4'h0, "R1", host_sd_oe, 4'h0, {tag, " host oe in opcode"});
        chk(flash_sd_oe == 4'h1 && flash_sd_o[0] == op[7 - t], "R1",
            flash_sd_oe, 4'h1, {tag, " opcode forward"});
        chk(host_sd_o == fdat(t), "R3", host_sd_o, fdat(t), {tag, " direct in opcode"});
      end else if (!v) begin
        chk(host_sd_oe == 4'h2 && flash_sd_oe == 4'h1, "R10", host_sd_oe, 4'h2,
            {tag, " bypass enables"});
        chk(host_sd_o == fdat(t), "R10", host_sd_o, fdat(t), {tag, " bypass data"});
      end else if (t < 8 + a_len) begin
        chk(host_sd_oe == 4'h0 && flash_sd_oe == 4'h1, "R2", flash_sd_oe, 4'h1,
            {tag, " address phase"});
      end else if (t < d0) begin
        chk(host_sd_oe == 4'h0 && flash_sd_oe == 4'h0, (hd > 8) ? "R6" : "R5",
            host_sd_oe | flash_sd_oe, 4'h0, {tag, " dummy window"});
      end else begin
        chk(host_sd_oe == exp_mask(ln), "R8", host_sd_oe, exp_mask(ln), {tag, " lanes"});
        ev = eff ? fdat(t - DEPTH) : fdat(t);
        chk(host_sd_o == ev, eff ? "R4" : ((op == 8'h03) ? "R7" : "R3"),
            host_sd_o, ev, {tag, " read data"});
      end
      @(negedge sck);
    end
    host_csb  = 1'b1;
    host_sd_i = 4'h0;
    #1;
    chk(host_sd_oe == 4'h0 && flash_sd_oe == 4'h0, "R9", host_sd_oe | flash_sd_oe, 4'h0,
        {tag, " release on deselect"});
    @(negedge sck);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge sck);
    #1;
    chk(host_sd_oe == 4'h0 && flash_sd_oe == 4'h0, "R9", host_sd_oe, 4'h0, "reset state");
    rst_n = 1'b1;
    @(negedge sck);

    // Empty table after reset: every opcode bypasses (R11, R10)
    run_txn(8'h0B, 1'b0, 1'b0, 2'd0, 2'd0, 4'd0, 6, -1, "R11 empty table");

    prog(0, 1'b1, 8'h03, 1'b1, 2'd0, 2'd3, 4'd0);
    prog(1, 1'b1, 8'h0B, 1'b1, 2'd0, 2'd3, 4'd8);
    prog(2, 1'b1, 8'h3B, 1'b1, 2'd1, 2'd3, 4'd4);
    prog(3, 1'b1, 8'h6B, 1'b1, 2'd2, 2'd3, 4'd2);

    run_txn(8'h03, 1'b1, 1'b1, 2'd0, 2'd3, 4'd0, 8, -1, "R7 plain read");
    run_txn(8'h0B, 1'b1, 1'b1, 2'd0, 2'd3, 4'd8, 8, -1, "R6 fast read");
    run_txn(8'h3B, 1'b1, 1'b1, 2'd1, 2'd3, 4'd4, 8, -1, "R4 dual read");
    run_txn(8'h6B, 1'b1, 1'b1, 2'd2, 2'd3, 4'd2, 8, -1, "R4 quad read");

    // Abort in the address phase, then a clean transaction (R9)
    run_txn(8'h6B, 1'b1, 1'b1, 2'd2, 2'd3, 4'd2, 8, 12, "R9 abort");
    run_txn(8'h3B, 1'b1, 1'b1, 2'd1, 2'd3, 4'd4, 8, -1, "R9 after abort");

    run_txn(8'h9F, 1'b0, 1'b0, 2'd0, 2'd0, 4'd0, 8, -1, "R10 unknown opcode");

    // Sweep over entry fields on one slot
    for (int p = 0; p < 2; p++) begin
      for (int ln = 0; ln < 4; ln++) begin
        for (int ai = 0; ai < 3; ai++) begin
          for (int di = 0; di < 4; di++) begin
            logic [1:0] ab;
            logic [3:0] nd;
            logic [7:0] op;
            ab = (ai == 2) ? 2'd3 : 2'(ai);
            nd = (di == 0) ? 4'd0 : (di == 1) ? 4'd1 : (di == 2) ? 4'd7 : 4'd13;
            op = 8'hA0 + 8'(ln * 4 + di);
            prog(0, 1'b1, op, 1'(p), 2'(ln), ab, nd);
            run_txn(op, 1'b1, 1'(p), 2'(ln), ab, nd, 5, -1, "R2 R8 sweep");
          end
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule